// File: doc/BRIEF.md
# Rotating-Register Subkey Sequencer

This block produces the subkeys for a 256-bit tweakable block cipher. It takes a 256-bit key and a 128-bit tweak. On a load it derives one extra key word and one extra tweak word. It then holds five key words and three tweak words in two rotating word rings. Every accepted step moves both rings by one word position, and the block forms the next subkey from the words that sit at the front of the rings. The cipher rounds that use the subkeys are outside this block.

The block serves both encryption and decryption. A load with the direction input low starts at subkey 0 and counts up to subkey 18. A load with the direction input high starts at subkey 18 and counts down to subkey 0. For the reverse order, both rings are placed straight into the rotation they hold at subkey 18, so the first decryption subkey is ready in the cycle after the load and no forward pass is needed to reach it.

A small state machine tracks progress. It has four states. S_IDLE means no key is loaded. S_FWD means counting up. S_REV means counting down. S_END means the last subkey of the chosen order has been reached. The transitions are as follows. LOAD_FWD takes any state to S_FWD, and LOAD_REV takes any state to S_REV. FWD_LAST goes from S_FWD to S_END on the step that reaches index 18. REV_LAST goes from S_REV to S_END on the step that reaches index 0. Any other step keeps the current state.

Top module: `ks_subkey_gen`

## Requirements
- R1: After reset, valid_o is 0, index_o is 0 and subkey_o is all zero.
- R2: A load with dir_rev_i = 0 sets valid_o to 1 and index_o to 0 in the next cycle. The extended key word is k4 = 0x1BD11BDAA9FC1A22 ^ k0 ^ k1 ^ k2 ^ k3, and the extended tweak word is t2 = t0 ^ t1. Key word j is key_i[64j+63:64j], and tweak word j is tweak_i[64j+63:64j].
- R3: For index s, subkey_o word j (bits 64j+63:64j) holds the following values, with all additions taken mod 2^64:
  - word 0 = k[s mod 5]
  - word 1 = k[(s+1) mod 5] + t[s mod 3]
  - word 2 = k[(s+2) mod 5] + t[(s+1) mod 3]
  - word 3 = k[(s+3) mod 5] + s
- R4: In forward order, each cycle with step_i = 1 and load_i = 0 raises index_o by one, and subkey_o follows R3 for the new index.
- R5: A load with dir_rev_i = 1 sets valid_o to 1 and index_o to 18 in the next cycle, and subkey_o equals subkey 18 at once.
- R6: In reverse order, each step lowers index_o by one, and subkey_o follows R3 for the new index.
- R7: A step at index 18 in forward order, or at index 0 in reverse order, is ignored. index_o and subkey_o keep their values, and index_o never exceeds 18.
- R8: A cycle with step_i = 0 and load_i = 0 leaves index_o, subkey_o and valid_o unchanged.
- R9: load_i takes priority over step_i. A load in the middle of a sequence restarts it with the new key, tweak and direction.
- R10: step_i before any load is ignored. valid_o stays 0 and subkey_o stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture key, tweak and direction, and restart the sequence |
| key_i | input | 256 | Cipher key, four 64-bit words |
| tweak_i | input | 128 | Tweak, two 64-bit words |
| dir_rev_i | input | 1 | Order selected at load: 0 counts up, 1 counts down |
| step_i | input | 1 | Advance to the next subkey |
| subkey_o | output | 256 | Current subkey, four 64-bit words |
| index_o | output | 5 | Index of the current subkey |
| valid_o | output | 1 | A key has been loaded |

## Verification
On every cycle the assertions check four things:
- the index limit;
- the single-step movement of the index in the direction captured at load;
- that a step is ignored at the ends of the range and before any load;
- that outputs hold on idle cycles.

Only the bench scenarios can show that the subkey words themselves are correct. The bench computes each subkey from the key and tweak with a function of its own. It compares full forward and reverse sweeps, loads that arrive in the middle of a sequence, and random mixes of steps against that function. The bench also confirms that the reverse order reproduces the forward subkeys in mirror order.

// File: rtl/ks_pkg.sv
package ks_pkg;
    parameter int WORD_W      = 64;
    parameter int KEY_WORDS   = 4;
    parameter int TWEAK_WORDS = 2;
    parameter int LAST_IDX    = 18;
    parameter logic [WORD_W-1:0] PARITY_CONST = 64'h1BD1_1BDA_A9FC_1A22;

    localparam int EXT_KEY_WORDS   = KEY_WORDS + 1;
    localparam int EXT_TWEAK_WORDS = TWEAK_WORDS + 1;
    localparam int IDX_W           = $clog2(LAST_IDX + 1);

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FWD  = 2'd1,
        S_REV  = 2'd2,
        S_END  = 2'd3
    } ks_state_t;
endpackage

// File: rtl/ks_key_extend.sv
module ks_key_extend
    import ks_pkg::*;
(
    input  logic [KEY_WORDS*WORD_W-1:0]         key_i,
    input  logic [TWEAK_WORDS*WORD_W-1:0]       tweak_i,
    output logic [EXT_KEY_WORDS*WORD_W-1:0]     ext_key_o,
    output logic [EXT_TWEAK_WORDS*WORD_W-1:0]   ext_tweak_o
);
    logic [WORD_W-1:0] key_par [KEY_WORDS+1];
    logic [WORD_W-1:0] tw_par  [TWEAK_WORDS+1];

    assign key_par[0] = PARITY_CONST;
    assign tw_par[0]  = '0;

    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_kpar
        assign key_par[i+1] = key_par[i] ^ key_i[i*WORD_W +: WORD_W];
    end

    for (genvar i = 0; i < TWEAK_WORDS; i++) begin : g_tpar
        assign tw_par[i+1] = tw_par[i] ^ tweak_i[i*WORD_W +: WORD_W];
    end

    assign ext_key_o   = {key_par[KEY_WORDS], key_i};
    assign ext_tweak_o = {tw_par[TWEAK_WORDS], tweak_i};
endmodule

// File: rtl/ks_word_ring.sv
module ks_word_ring #(
    parameter int N_WORDS    = 5,
    parameter int W          = 64,
    parameter int PRESET_FWD = 0,
    parameter int PRESET_REV = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 load_rev_i,
    input  logic                 adv_fwd_i,
    input  logic                 adv_rev_i,
    input  logic [N_WORDS*W-1:0] din_i,
    output logic [N_WORDS*W-1:0] ring_o
);
    logic [W-1:0] slot [N_WORDS];

    for (genvar i = 0; i < N_WORDS; i++) begin : g_slot
        localparam int SRC_FWD  = (i + PRESET_FWD) % N_WORDS;
        localparam int SRC_REV  = (i + PRESET_REV) % N_WORDS;
        localparam int NEXT_UP  = (i + 1) % N_WORDS;
        localparam int NEXT_DN  = (i + N_WORDS - 1) % N_WORDS;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (load_i) begin
                slot[i] <= load_rev_i ? din_i[SRC_REV*W +: W]
                                      : din_i[SRC_FWD*W +: W];
            end else if (adv_fwd_i) begin
                slot[i] <= slot[NEXT_UP];
            end else if (adv_rev_i) begin
                slot[i] <= slot[NEXT_DN];
            end
        end

        assign ring_o[i*W +: W] = slot[i];
    end
endmodule

// File: rtl/ks_subkey_form.sv
module ks_subkey_form
    import ks_pkg::*;
(
    input  logic [EXT_KEY_WORDS*WORD_W-1:0]   kring_i,
    input  logic [EXT_TWEAK_WORDS*WORD_W-1:0] tring_i,
    input  logic [IDX_W-1:0]                  idx_i,
    output logic [KEY_WORDS*WORD_W-1:0]       subkey_o
);
    localparam int TOP = KEY_WORDS - 1;

    for (genvar j = 0; j < KEY_WORDS; j++) begin : g_word
        logic [WORD_W-1:0] addend;
        if (j == 0) begin : g_plain
            assign addend = '0;
        end else if (j == TOP) begin : g_count
            assign addend = {{(WORD_W-IDX_W){1'b0}}, idx_i};
        end else begin : g_tweak
            assign addend = tring_i[(j-1)*WORD_W +: WORD_W];
        end
        assign subkey_o[j*WORD_W +: WORD_W] = kring_i[j*WORD_W +: WORD_W] + addend;
    end
endmodule

// File: rtl/ks_subkey_gen.sv
module ks_subkey_gen
    import ks_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [KEY_WORDS*WORD_W-1:0]   key_i,
    input  logic [TWEAK_WORDS*WORD_W-1:0] tweak_i,
    input  logic                          dir_rev_i,
    input  logic                          step_i,
    output logic [KEY_WORDS*WORD_W-1:0]   subkey_o,
    output logic [IDX_W-1:0]              index_o,
    output logic                          valid_o
);
    localparam int KEY_PRESET_REV = LAST_IDX % EXT_KEY_WORDS;
    localparam int TW_PRESET_REV  = LAST_IDX % EXT_TWEAK_WORDS;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LAST_IDX);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    ks_state_t state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic adv_fwd, adv_rev;

    logic [EXT_KEY_WORDS*WORD_W-1:0]   ext_key, kring;
    logic [EXT_TWEAK_WORDS*WORD_W-1:0] ext_tw, tring;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = dir_rev_i ? S_REV : S_FWD;   // LOAD_REV / LOAD_FWD
        end else if (step_i) begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_FWD:  if (idx_q == IDX_LAST - IDX_ONE) state_d = S_END; // FWD_LAST
                S_REV:  if (idx_q == IDX_ONE) state_d = S_END;            // REV_LAST
                S_END:  state_d = S_END;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state-derived outputs and enables
    always_comb begin
        adv_fwd = 1'b0;
        adv_rev = 1'b0;
        valid_o = 1'b0;
        unique case (state_q)
            S_IDLE: valid_o = 1'b0;
            S_FWD:  begin valid_o = 1'b1; adv_fwd = step_i && !load_i; end
            S_REV:  begin valid_o = 1'b1; adv_rev = step_i && !load_i; end
            S_END:  valid_o = 1'b1;
            default: valid_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (load_i)  idx_q <= dir_rev_i ? IDX_LAST : '0;
        else if (adv_fwd) idx_q <= idx_q + IDX_ONE;
        else if (adv_rev) idx_q <= idx_q - IDX_ONE;
    end

    ks_key_extend u_ext (
        .key_i       (key_i),
        .tweak_i     (tweak_i),
        .ext_key_o   (ext_key),
        .ext_tweak_o (ext_tw)
    );

    ks_word_ring #(
        .N_WORDS(EXT_KEY_WORDS), .W(WORD_W),
        .PRESET_FWD(0), .PRESET_REV(KEY_PRESET_REV)
    ) u_kring (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_rev_i(dir_rev_i),
        .adv_fwd_i(adv_fwd), .adv_rev_i(adv_rev),
        .din_i(ext_key), .ring_o(kring)
    );

    ks_word_ring #(
        .N_WORDS(EXT_TWEAK_WORDS), .W(WORD_W),
        .PRESET_FWD(0), .PRESET_REV(TW_PRESET_REV)
    ) u_tring (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_rev_i(dir_rev_i),
        .adv_fwd_i(adv_fwd), .adv_rev_i(adv_rev),
        .din_i(ext_tw), .ring_o(tring)
    );

    ks_subkey_form u_form (
        .kring_i  (kring),
        .tring_i  (tring),
        .idx_i    (idx_q),
        .subkey_o (subkey_o)
    );

    assign index_o = idx_q;
endmodule

// File: rtl/ks_subkey_gen_chk.sv
module ks_subkey_gen_chk
    import ks_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        load_i,
    input logic                        dir_rev_i,
    input logic                        step_i,
    input logic [KEY_WORDS*WORD_W-1:0] subkey_o,
    input logic [IDX_W-1:0]            index_o,
    input logic                        valid_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LAST_IDX);

    logic dir_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_seen <= 1'b0;
        else if (load_i) dir_seen <= dir_rev_i;
    end

    assert_index_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        index_o <= IDX_LAST);

    assert_fwd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && step_i && !load_i && !dir_seen && index_o != IDX_LAST
        |=> index_o == $past(index_o) + 1'b1);

    assert_rev_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && step_i && !load_i && dir_seen && index_o != '0
        |=> index_o == $past(index_o) - 1'b1);

    assert_end_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !load_i && ((!dir_seen && index_o == IDX_LAST) || (dir_seen && index_o == '0))
        |=> $stable(index_o) && $stable(subkey_o));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i && !load_i |=> $stable(index_o) && $stable(subkey_o) && $stable(valid_o));

    assert_load_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> valid_o && index_o == ($past(dir_rev_i) ? IDX_LAST : '0));

    assert_no_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && !load_i |=> !valid_o && subkey_o == '0);
endmodule

bind ks_subkey_gen ks_subkey_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .dir_rev_i(dir_rev_i),
    .step_i(step_i), .subkey_o(subkey_o), .index_o(index_o), .valid_o(valid_o)
);

// File: tb/ks_subkey_gen_tb.sv
module ks_subkey_gen_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [255:0] key_i = '0;
    logic [127:0] tweak_i = '0;
    logic         dir_rev_i = 1'b0;
    logic         step_i = 1'b0;
    logic [255:0] subkey_o;
    logic [4:0]   index_o;
    logic         valid_o;

    int n_tests = 0;
    int n_fail  = 0;

    // expected-state model
    logic         m_valid = 1'b0;
    logic         m_rev = 1'b0;
    int           m_idx = 0;
    logic [255:0] m_key = '0;
    logic [127:0] m_tw = '0;

    always #4 clk = ~clk;

    ks_subkey_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i),
        .tweak_i(tweak_i), .dir_rev_i(dir_rev_i), .step_i(step_i),
        .subkey_o(subkey_o), .index_o(index_o), .valid_o(valid_o)
    );

    function automatic logic [255:0] ref_subkey(input logic [255:0] key,
                                                input logic [127:0] tw, input int s);
        logic [63:0] k [5];
        logic [63:0] t [3];
        logic [255:0] r;
        k[4] = 64'h1BD11BDAA9FC1A22;
        for (int i = 0; i < 4; i++) begin
            k[i] = key[i*64 +: 64];
            k[4] = k[4] ^ k[i];
        end
        t[0] = tw[63:0];
        t[1] = tw[127:64];
        t[2] = t[0] ^ t[1];
        r[63:0]    = k[s % 5];
        r[127:64]  = k[(s+1) % 5] + t[s % 3];
        r[191:128] = k[(s+2) % 5] + t[(s+1) % 3];
        r[255:192] = k[(s+3) % 5] + 64'(s);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input logic ld, input logic rev, input logic st,
                         input logic [255:0] k, input logic [127:0] tw);
        @(negedge clk);
        load_i = ld; dir_rev_i = rev; step_i = st; key_i = k; tweak_i = tw;
        if (ld) begin
            m_valid = 1'b1; m_rev = rev; m_idx = rev ? 18 : 0; m_key = k; m_tw = tw;
        end else if (m_valid && st) begin
            if (!m_rev && m_idx < 18) m_idx++;
            else if (m_rev && m_idx > 0) m_idx--;
        end
        @(posedge clk);
        #2;
    endtask

    task automatic check_model(input string req);
        logic [255:0] exp;
        exp = m_valid ? ref_subkey(m_key, m_tw, m_idx) : '0;
        check(valid_o == m_valid, req, "valid", 256'(valid_o), 256'(m_valid));
        check(index_o == 5'(m_idx), req, "index", 256'(index_o), 256'(m_idx));
        check(subkey_o == exp, req, "subkey", subkey_o, exp);
    endtask

    function automatic logic [255:0] rnd_key();
        return {$urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [255:0] k;
        logic [127:0] tw;
        logic [255:0] fwd_keys [19];
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #2;
        check(valid_o == 1'b0, "R1", "valid after reset", 256'(valid_o), 256'd0);
        check(index_o == 5'd0, "R1", "index after reset", 256'(index_o), 256'd0);
        check(subkey_o == '0, "R1", "subkey after reset", subkey_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // step before any load
        cycle(1'b0, 1'b0, 1'b1, '0, '0);
        check_model("R10");
        cycle(1'b0, 1'b1, 1'b1, '0, '0);
        check_model("R10");

        // forward sweep with an all-zero key: k4 is the constant alone
        cycle(1'b1, 1'b0, 1'b0, '0, '0);
        check_model("R2");
        check(subkey_o[255:192] == 64'h1BD11BDAA9FC1A22 ? 1'b0 : 1'b1, "R2",
              "zero key word3", subkey_o, '0);
        // with a zero key, subkey 0 word 3 = k3 = 0

        // forward sweep with a random key
        k = rnd_key();
        tw = {$urandom, $urandom, $urandom, $urandom};
        cycle(1'b1, 1'b0, 1'b0, k, tw);
        check_model("R2");
        check(subkey_o == ref_subkey(k, tw, 0), "R3", "subkey 0", subkey_o, ref_subkey(k, tw, 0));
        fwd_keys[0] = subkey_o;
        for (int s = 1; s <= 18; s++) begin
            cycle(1'b0, 1'b0, 1'b1, k, tw);
            check_model("R4");
            fwd_keys[s] = subkey_o;
        end
        cycle(1'b0, 1'b0, 1'b1, k, tw);
        check_model("R7");
        check(index_o == 5'd18, "R7", "forward end hold", 256'(index_o), 256'd18);
        cycle(1'b0, 1'b0, 1'b0, k, tw);
        check_model("R8");

        // reverse sweep with the same key mirrors the forward subkeys
        cycle(1'b1, 1'b1, 1'b0, k, tw);
        check_model("R5");
        check(subkey_o == fwd_keys[18], "R5", "first reverse subkey", subkey_o, fwd_keys[18]);
        for (int s = 17; s >= 0; s--) begin
            cycle(1'b0, 1'b1, 1'b1, k, tw);
            check_model("R6");
            check(subkey_o == fwd_keys[s], "R6", "mirror subkey", subkey_o, fwd_keys[s]);
        end
        cycle(1'b0, 1'b1, 1'b1, k, tw);
        check_model("R7");
        check(index_o == 5'd0, "R7", "reverse end hold", 256'(index_o), 256'd0);

        // load in mid-sequence wins over step
        k = rnd_key();
        cycle(1'b1, 1'b0, 1'b0, k, tw);
        repeat (5) cycle(1'b0, 1'b0, 1'b1, k, tw);
        check_model("R4");
        k = rnd_key();
        tw = {$urandom, $urandom, $urandom, $urandom};
        cycle(1'b1, 1'b1, 1'b1, k, tw);
        check_model("R9");
        check(index_o == 5'd18, "R9", "load beats step", 256'(index_o), 256'd18);
        repeat (3) cycle(1'b0, 1'b1, 1'b1, k, tw);
        cycle(1'b1, 1'b0, 1'b1, rnd_key(), tw);
        check_model("R9");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic ld;
            ld = ($urandom % 24) == 0;
            cycle(ld, 1'($urandom), 1'($urandom), ld ? rnd_key() : 256'($urandom),
                  {$urandom, $urandom, $urandom, $urandom});
            check_model(ld ? "R9" : (m_rev ? "R6" : "R4"));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule